// File: doc/BRIEF.md
# Ready-Line Stall Controller with Programmable Lag

This block watches a wait/ready line that one or more external devices drive, and produces a stall signal. The stall freezes the state sequencer of a host memory bus controller. The ready line is sampled on every rising bus clock edge. Each not-ready sample enters a short shift register. The stall output is taken from the stage that a 2-bit lag setting selects, so the stall appears one, two or three bus cycles after the sample that caused it.

A polarity control chooses whether a low or a high level on the line means not-ready. This lets a shared, pulled-up line serve devices of either convention. A monitor enable turns the whole mechanism off. A small demo sequencer is included, which steps a beat counter on each advance request the stall does not block. It shows that every data beat is kept, even across stalls.

Top module: `ready_stall_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `stall` is 0 and `beat_idx` is 0.
- R2: While `mon_en` is 0, `stall` is 0 whatever level `rdy_in` has.
- R3: With `pol_inv` = 0, a low sample of `rdy_in` means not-ready. With `pol_inv` = 1, a high sample means not-ready.
- R4: With `dly_sel` = 2'b01, a not-ready sample at rising edge k raises `stall` right after edge k. That stall blocks the beat advance at edge k+1.
- R5: With `dly_sel` = 2'b10 or 2'b11, `stall` rises right after edge k+1 or edge k+2 respectively (a lag of 2 or 3 cycles).
- R6: `dly_sel` = 2'b00 behaves exactly like 2'b01.
- R7: A run of n consecutive not-ready samples keeps `stall` high for exactly n cycles. `beat_idx` does not change at any edge where `stall` was high before the edge.
- R8: After ready returns, `stall` falls after the same programmed lag. Across a stall, `beat_idx` advances by exactly one at every unblocked edge, so no beat is skipped or repeated.
- R9: `adv_ok` equals `adv_req` AND NOT `stall`. `beat_idx` increments by one, modulo 2^BEAT_W, at each edge where `adv_ok` is 1, and is otherwise unchanged.
- R10: Clearing `mon_en` while a stall is in effect drops `stall` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Enables monitoring of the ready line |
| pol_inv | input | 1 | 0: low means not-ready; 1: high means not-ready |
| dly_sel | input | 2 | Stall lag: 00/01 one cycle, 10 two, 11 three |
| rdy_in | input | 1 | Shared wait/ready line |
| adv_req | input | 1 | Sequencer request to move to the next beat |
| stall | output | 1 | Stall applied to the sequencer |
| adv_ok | output | 1 | Advance request that passed the stall gate |
| beat_idx | output | BEAT_W | Current data beat of the demo sequencer |

## Verification
A corrupted stage in the lag pipeline shows up on `stall` within at most three cycles. It appears as a stall pulse that starts at the wrong edge or lasts the wrong length. Since the beat counter is gated by that pulse, the same fault also leaves `beat_idx` off by one. That offset persists for the rest of the run, so a single wrong cycle stays visible at the ports. The bench compares both outputs against the expected stall window for every lag code, both polarities, several run lengths, and a change of the enable in the middle of a stall.

// File: rtl/rdy_stall_pkg.sv
package rdy_stall_pkg;

    // Deepest lag the pipeline supports, in bus cycles
    localparam int MAX_LAG = 3;
    localparam int TAP_W   = $clog2(MAX_LAG);

    typedef enum logic [1:0] {
        LAG_RSVD  = 2'b00,
        LAG_ONE   = 2'b01,
        LAG_TWO   = 2'b10,
        LAG_THREE = 2'b11
    } lag_code_t;

    typedef logic [MAX_LAG-1:0] lag_pipe_t;

    // Ready-line configuration travelling as one bundle
    typedef struct packed {
        logic      enable;
        logic      invert;
        lag_code_t lag;
    } rdy_cfg_t;

    // Pipeline stage index for a lag code; the reserved code maps to one cycle
    function automatic logic [TAP_W-1:0] tap_of(input lag_code_t code);
        logic [TAP_W-1:0] t;
        case (code)
            LAG_TWO:   t = TAP_W'(1);
            LAG_THREE: t = TAP_W'(2);
            default:   t = TAP_W'(0);
        endcase
        return t;
    endfunction

    // True when the sampled line level means "not ready"
    function automatic logic is_not_ready(input logic level, input logic invert);
        return invert ? level : ~level;
    endfunction

endpackage

// File: rtl/rdy_level_decode.sv
module rdy_level_decode
    import rdy_stall_pkg::*;
(
    input  rdy_cfg_t cfg,
    input  logic     rdy_in,
    output logic     not_ready
);
    always_comb begin
        not_ready = cfg.enable & is_not_ready(rdy_in, cfg.invert);
    end
endmodule

// File: rtl/stall_lag_line.sv
module stall_lag_line
    import rdy_stall_pkg::*;
#(
    parameter int DEPTH = MAX_LAG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample,
    input  logic [$clog2(DEPTH)-1:0]  tap,
    output logic                      tap_out
);
    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= sample;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= 1'b0;
            else     stage_q[i] <= stage_q[i-1];
        end
    end

    always_comb begin
        tap_out = stage_q[tap];
    end
endmodule

// File: rtl/beat_stepper.sv
module beat_stepper #(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);
    always_ff @(posedge clk) begin
        if (rst)       beat <= '0;
        else if (step) beat <= beat + BEAT_W'(1);
    end
endmodule

// File: rtl/ready_stall_ctrl.sv
module ready_stall_ctrl
    import rdy_stall_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_en,
    input  logic              pol_inv,
    input  logic [1:0]        dly_sel,
    input  logic              rdy_in,
    input  logic              adv_req,
    output logic              stall,
    output logic              adv_ok,
    output logic [BEAT_W-1:0] beat_idx
);
    rdy_cfg_t         cfg;
    logic             nr_sample;
    logic             lag_hit;
    logic [TAP_W-1:0] tap_sel;

    always_comb begin
        cfg.enable = mon_en;
        cfg.invert = pol_inv;
        cfg.lag    = lag_code_t'(dly_sel);
        tap_sel    = tap_of(cfg.lag);
    end

    rdy_level_decode u_decode (
        .cfg       (cfg),
        .rdy_in    (rdy_in),
        .not_ready (nr_sample)
    );

    stall_lag_line #(.DEPTH(MAX_LAG)) u_lag (
        .clk     (clk),
        .rst     (rst),
        .sample  (nr_sample),
        .tap     (tap_sel),
        .tap_out (lag_hit)
    );

    // Enable also masks the output so turning monitoring off acts at once
    always_comb begin
        stall  = cfg.enable & lag_hit;
        adv_ok = adv_req & ~stall;
    end

    beat_stepper #(.BEAT_W(BEAT_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (adv_ok),
        .beat (beat_idx)
    );
endmodule

// File: rtl/ready_stall_ctrl_chk.sv
module ready_stall_ctrl_chk #(
    parameter int BEAT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mon_en,
    input logic              pol_inv,
    input logic [1:0]        dly_sel,
    input logic              rdy_in,
    input logic              adv_req,
    input logic              stall,
    input logic              adv_ok,
    input logic [BEAT_W-1:0] beat_idx
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (!stall && beat_idx == '0));

    // R2
    disabled_no_stall_chk: assert property (@(posedge clk) disable iff (rst) !mon_en |-> !stall);

    // R4
    lag_one_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && dly_sel == 2'b01 && !pol_inv && !rdy_in) ##1 (mon_en && dly_sel == 2'b01) |-> stall);

    // R7
    stall_holds_beat_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(beat_idx));

    // R9
    advance_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_req && !stall) |=> beat_idx == $past(beat_idx) + BEAT_W'(1));

    // R9
    idle_holds_beat_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_req |=> $stable(beat_idx));

    // R9
    gate_relation_chk: assert property (@(posedge clk) disable iff (rst)
        adv_ok |-> (adv_req && !stall));
endmodule

bind ready_stall_ctrl ready_stall_ctrl_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mon_en   (mon_en),
    .pol_inv  (pol_inv),
    .dly_sel  (dly_sel),
    .rdy_in   (rdy_in),
    .adv_req  (adv_req),
    .stall    (stall),
    .adv_ok   (adv_ok),
    .beat_idx (beat_idx)
);

// File: tb/ready_stall_ctrl_bench.sv
module ready_stall_ctrl_bench;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          mon_en, pol_inv, rdy_in, adv_req;
    logic [1:0]    dly_sel;
    logic          stall, adv_ok;
    logic [BW-1:0] beat_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ready_stall_ctrl #(.BEAT_W(BW)) u_ready_stall_ctrl (
        .clk(clk), .rst(rst), .mon_en(mon_en), .pol_inv(pol_inv),
        .dly_sel(dly_sel), .rdy_in(rdy_in), .adv_req(adv_req),
        .stall(stall), .adv_ok(adv_ok), .beat_idx(beat_idx)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // advance one edge, then sample 1 ns after it
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; mon_en = 1'b1; pol_inv = 1'b0; dly_sel = 2'b01;
        rdy_in = 1'b1; adv_req = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "stall", int'(stall), 0);
        check("R1", "beat", int'(beat_idx), 0);
    endtask

    // Not-ready for len samples; expect a len-cycle stall after lag d
    task automatic t_pulse(input string req, input logic [1:0] code, input int d,
                           input logic inv, input int len);
        logic [BW-1:0] b_exp;
        logic          prev_exp;
        logic          s_exp;
        pol_inv = inv; dly_sel = code; mon_en = 1'b1; adv_req = 1'b1;
        rdy_in  = ~inv;
        for (int i = 0; i < 4; i++) cyc();
        b_exp    = beat_idx;
        prev_exp = 1'b0;
        rdy_in   = inv;
        for (int j = 0; j < len + d + 2; j++) begin
            cyc();
            if (j == len - 1) rdy_in = ~inv;
            s_exp = (j >= d - 1) && (j <= d - 2 + len);
            if (!prev_exp) b_exp = b_exp + BW'(1);
            check(req, "stall", int'(stall), int'(s_exp));
            check("R8", "beat", int'(beat_idx), int'(b_exp));
            prev_exp = s_exp;
        end
    endtask

    task automatic t_disabled();
        logic [BW-1:0] b0;
        mon_en = 1'b0; pol_inv = 1'b0; dly_sel = 2'b11; rdy_in = 1'b0;
        cyc();
        b0 = beat_idx;
        for (int i = 1; i <= 6; i++) begin
            cyc();
            check("R2", "stall", int'(stall), 0);
            check("R2", "beat", int'(beat_idx), int'(b0 + BW'(i)));
        end
        rdy_in = 1'b1; mon_en = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
    endtask

    task automatic t_drop_enable();
        mon_en = 1'b1; pol_inv = 1'b0; dly_sel = 2'b01; rdy_in = 1'b0;
        cyc(); cyc();
        check("R10", "stall before drop", int'(stall), 1);
        mon_en = 1'b0;
        #1;
        check("R10", "stall after drop", int'(stall), 0);
        check("R9", "adv_ok after drop", int'(adv_ok), 1);
        rdy_in = 1'b1;
        cyc(); cyc(); cyc(); cyc();
        mon_en = 1'b1;
    endtask

    task automatic t_idle_and_wrap();
        logic [BW-1:0] b0;
        adv_req = 1'b0; rdy_in = 1'b1;
        cyc();
        b0 = beat_idx;
        cyc(); cyc();
        check("R9", "beat held without request", int'(beat_idx), int'(b0));
        check("R9", "adv_ok low", int'(adv_ok), 0);
        adv_req = 1'b1;
        for (int i = 0; i < (1 << BW); i++) cyc();
        check("R9", "beat after full wrap", int'(beat_idx), int'(b0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pulse("R4", 2'b01, 1, 1'b0, 1);
        t_pulse("R5", 2'b10, 2, 1'b0, 1);
        t_pulse("R5", 2'b11, 3, 1'b0, 1);
        t_pulse("R6", 2'b00, 1, 1'b0, 2);
        t_pulse("R3", 2'b01, 1, 1'b1, 2);
        t_pulse("R7", 2'b10, 2, 1'b0, 3);
        t_pulse("R7", 2'b11, 3, 1'b1, 4);
        t_disabled();
        t_drop_enable();
        t_idle_and_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule